// File: doc/BRIEF.md
# Event Timer Comparator Channel

One comparator channel of a multi-channel event-timer peripheral. The channel watches a shared 64-bit main counter that is supplied from outside, together with a global enable. When the counter reaches the channel's comparator, the channel raises a one-cycle interrupt request. The channel can run in three ways:

- **One-shot:** the comparator holds still after a match.
- **Periodic:** the comparator moves forward by a hidden period on each match.
- **Narrowed 32-bit mode:** only the low halves of the comparator and counter take part.

The channel also handles the case where a 32-bit one-shot target lies behind the counter. In that case the counter must roll over before the real match.

Software reaches the channel through 32-bit reads and writes at byte offsets within the channel's 0x20-byte window. The parent decodes the window base, so the channel sees only the 5-bit offset. The hidden period register is loaded through the comparator offsets. A self-clearing "load comparator" flag selects whether a write in periodic mode also moves the comparator. The channel drives a route number taken from its configuration so that the parent can steer the interrupt. It also drives the signed, clamped number of ticks left before the next match.

Top module: `evt_chan`

## Requirements
- R1: After reset, the configuration low word reads 0x00000030. Bit 4 is periodic-capable and bit 5 is 64-bit-capable, both constant. The comparator reads all ones in both halves. `irq_pulse` is 0 and `irq_route` is 0.
- R2: A write to offset 0x00 changes only the bits outside mask 0xFFFF80B1. The writable bits are:
  - bit 1: level type, stored with no effect
  - bit 2: channel enable
  - bit 3: periodic
  - bit 6: load-comparator
  - bit 8: 32-bit mode
  - bits 13:9: route
  - bit 14: spare

  `irq_route` always equals bits 13:9.
- R3: A configuration write with bit 8 set clears the upper halves of the comparator and the period in the same cycle. While bit 8 is set, the comparator upper half stays 0, including after writes to offset 0x0C.
- R4: A write to offset 0x08 (comparator low half) or 0x0C (comparator high half) updates that half of the comparator when the channel is one-shot or the load-comparator bit is 1.
- R5: In periodic mode, a write to offset 0x08 always loads the period low half. A write to offset 0x0C with the load-comparator bit at 0 loads only the period upper half and leaves the comparator unchanged.
- R6: Period writes force the top bit of the period to 0. This is bit 31 in 32-bit mode and bit 63 otherwise.
- R7: The load-comparator bit reads 0 after any write to offset 0x08 or 0x0C.
- R8: When `cnt_run` is 1, the channel enable is 1, and the counter equals the comparator (low halves only in 32-bit mode) at a clock edge, `irq_pulse` is 1 for the one cycle that follows that edge. If either enable is 0, no pulse is produced.
- R9: In periodic mode with a nonzero period, each match adds the period to the comparator, modulo 2^32 in 32-bit mode. If the comparator is still not ahead of the counter, one more period is added on each following cycle until it is. A one-shot comparator never moves by itself.
- R10: `ticks_left` is comparator minus counter, taken as signed. It is clamped to 0 when not positive, and uses only the low 32 bits in 32-bit mode.
- R11: In 32-bit one-shot mode, a comparator write whose new low half is less than or equal to the counter low half arms a wrap state. While armed:
  - matches are suppressed;
  - the counter low half reading all ones with `cnt_run` 1 produces a pulse and disarms the state;
  - the next match is then the real expiry.
- R12: Offset 0x04 reads the `ROUTE_CAP` parameter. Offsets 0x10 and 0x14 read 0. Writes to these three offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset within the channel window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| main_cnt | input | 64 | Shared main counter value |
| cnt_run | input | 1 | Global enable of counting and interrupts |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_route | output | RTE_W | Route number from the configuration |
| ticks_left | output | 64 | Clamped signed distance to the next match |

## Verification
A wrong comparator state shows up at once on `ticks_left` and on the comparator read-back. It shows up on `irq_pulse` only in the cycle after the counter would have matched. That is why the bench checks both the read-back and the pulse timing.

A stale catch-up or wrap flag leaves no trace in any register. It only shows as a missing, extra or early pulse, or as a comparator that lands on the wrong multiple of the period a few cycles after a counter jump. The bench therefore holds the counter still after a jump and reads the comparator once the catch-up must have ended.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;

  localparam int DW    = 64;
  localparam int HW    = 32;
  localparam int OFF_W = 5;

  // register offsets inside the channel window
  localparam logic [OFF_W-1:0] OFF_CFG_LO = 5'h00;
  localparam logic [OFF_W-1:0] OFF_CFG_HI = 5'h04;
  localparam logic [OFF_W-1:0] OFF_CMP_LO = 5'h08;
  localparam logic [OFF_W-1:0] OFF_CMP_HI = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_RTE_LO = 5'h10;
  localparam logic [OFF_W-1:0] OFF_RTE_HI = 5'h14;

  // configuration bit positions
  localparam int B_EN   = 2;
  localparam int B_PER  = 3;
  localparam int B_PCAP = 4;
  localparam int B_SZ   = 5;
  localparam int B_SETV = 6;
  localparam int B_M32  = 8;
  localparam int B_RT   = 9;

  localparam logic [HW-1:0] CFG_KEEP_MASK = 32'hFFFF_80B1;

  // distance from counter to comparator, clamped to zero when not ahead
  function automatic logic [DW-1:0] ticks_remaining(input logic [DW-1:0] cmp,
                                                    input logic [DW-1:0] cnt,
                                                    input logic narrow);
    logic [HW-1:0] d32;
    logic [DW-1:0] d64;
    d32 = cmp[HW-1:0] - cnt[HW-1:0];
    d64 = cmp - cnt;
    if (narrow)
      return (d32[HW-1] || d32 == '0) ? '0 : {{(DW-HW){1'b0}}, d32};
    return (d64[DW-1] || d64 == '0) ? '0 : d64;
  endfunction

  function automatic logic cmp_hit(input logic [DW-1:0] cmp,
                                   input logic [DW-1:0] cnt,
                                   input logic narrow);
    return narrow ? (cmp[HW-1:0] == cnt[HW-1:0]) : (cmp == cnt);
  endfunction

  function automatic logic [DW-1:0] cmp_step(input logic [DW-1:0] cmp,
                                             input logic [DW-1:0] per,
                                             input logic narrow);
    logic [HW-1:0] s32;
    s32 = cmp[HW-1:0] + per[HW-1:0];
    return narrow ? {{(DW-HW){1'b0}}, s32} : (cmp + per);
  endfunction

  // value stored into one half of the period; top bit of the period is cleared
  function automatic logic [HW-1:0] period_half(input logic [HW-1:0] d,
                                                input logic narrow,
                                                input logic upper);
    if (upper && narrow) return '0;
    if (upper || narrow) return {1'b0, d[HW-2:0]};
    return d;
  endfunction

endpackage

// File: rtl/evt_chan_cfg.sv
module evt_chan_cfg
  import evt_chan_pkg::*;
#(
  parameter bit PER_CAP = 1'b1,
  parameter int RTE_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [HW-1:0]    wdata,
  input  logic             cmp_wr,
  output logic [HW-1:0]    cfg_lo,
  output logic             ch_en,
  output logic             periodic,
  output logic             setval,
  output logic             m32,
  output logic [RTE_W-1:0] route,
  output logic             trunc
);

  logic [HW-1:0] keep_mask;
  logic [HW-1:0] bits_q;
  logic [HW-1:0] fixed_bits;

  generate
    if (PER_CAP) begin : g_per
      assign keep_mask = CFG_KEEP_MASK;
    end else begin : g_noper
      assign keep_mask = CFG_KEEP_MASK | (32'd1 << B_PER);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bits_q <= '0;
    else if (cfg_wr)
      bits_q <= wdata & ~keep_mask;
    else if (cmp_wr)
      bits_q[B_SETV] <= 1'b0;
  end

  always_comb begin
    fixed_bits         = '0;
    fixed_bits[B_PCAP] = PER_CAP;
    fixed_bits[B_SZ]   = 1'b1;
  end

  assign cfg_lo   = bits_q | fixed_bits;
  assign ch_en    = bits_q[B_EN];
  assign periodic = bits_q[B_PER];
  assign setval   = bits_q[B_SETV];
  assign m32      = bits_q[B_M32];
  assign route    = bits_q[B_RT +: RTE_W];
  assign trunc    = cfg_wr && wdata[B_M32];

  // R7: load-comparator flag is gone after any comparator write
  p_setval_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_wr) |-> !setval);

  // R2: read-only bits never move
  p_keep_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lo & CFG_KEEP_MASK) == (fixed_bits & CFG_KEEP_MASK));

endmodule

// File: rtl/evt_chan_cmp.sv
module evt_chan_cmp
  import evt_chan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [HW-1:0] wdata,
  input  logic          trunc,
  input  logic          mode_exit,
  input  logic          ch_en,
  input  logic          periodic,
  input  logic          setval,
  input  logic          m32,
  input  logic [DW-1:0] cnt,
  input  logic          glb_en,
  output logic [DW-1:0] cmp_q,
  output logic [DW-1:0] ticks_left,
  output logic          irq_pulse
);

  logic [DW-1:0] per_q;
  logic          catch_q;
  logic          wrap_q;

  logic          any_wr;
  logic          load_cmp;
  logic [DW-1:0] cmp_wval;
  logic          hit;
  logic          ahead;
  logic          adv_en;
  logic          wrap_evt;
  logic          wrap_arm;
  logic          irq_d;

  assign any_wr   = lo_wr || hi_wr;
  assign load_cmp = any_wr && (!periodic || setval);

  always_comb begin
    cmp_wval = cmp_q;
    if (lo_wr) begin
      cmp_wval[HW-1:0] = wdata;
      if (m32) cmp_wval[DW-1:HW] = '0;
    end else if (hi_wr) begin
      cmp_wval[DW-1:HW] = m32 ? '0 : wdata;
    end
  end

  assign hit        = cmp_hit(cmp_q, cnt, m32);
  assign ticks_left = ticks_remaining(cmp_q, cnt, m32);
  assign ahead      = ticks_left != '0;
  assign adv_en     = glb_en && periodic && (per_q != '0) && !any_wr && !trunc &&
                      (hit || (catch_q && !ahead));
  assign wrap_evt   = glb_en && wrap_q && (cnt[HW-1:0] == '1);
  assign wrap_arm   = any_wr && m32 && !periodic;
  assign irq_d      = glb_en && ch_en && ((hit && !wrap_q) || wrap_evt);

  // comparator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmp_q <= '1;
    else if (trunc)
      cmp_q <= {{(DW-HW){1'b0}}, cmp_q[HW-1:0]};
    else if (load_cmp)
      cmp_q <= cmp_wval;
    else if (adv_en)
      cmp_q <= cmp_step(cmp_q, per_q, m32);
  end

  // hidden period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      per_q <= '0;
    else if (trunc)
      per_q <= {{(DW-HW){1'b0}}, per_q[HW-1:0]};
    else if (lo_wr && periodic)
      per_q[HW-1:0] <= period_half(wdata, m32, 1'b0);
    else if (hi_wr && periodic && !setval)
      per_q[DW-1:HW] <= period_half(wdata, m32, 1'b1);
  end

  // catch-up and wrap state, interrupt register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      catch_q   <= 1'b0;
      wrap_q    <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      catch_q   <= adv_en;
      irq_pulse <= irq_d;
      if (wrap_arm)
        wrap_q <= (cmp_wval[HW-1:0] <= cnt[HW-1:0]);
      else if (mode_exit || wrap_evt)
        wrap_q <= 1'b0;
    end
  end

  // R8: a pulse only follows a cycle with both enables on
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(glb_en && ch_en));

  // R3: narrowed comparator keeps a zero upper half
  p_cmp_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m32 |-> cmp_q[DW-1:HW] == '0);

  // R6: the period never carries its top bit
  p_period_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !per_q[DW-1]);

  // R11: a rollover event disarms the wrap state unless a write re-arms it
  p_wrap_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && !any_wr |=> !wrap_q);

  // R9: a one-shot comparator without writes stays put
  p_oneshot_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !periodic && !any_wr && !trunc |=> $stable(cmp_q));

endmodule

// File: rtl/evt_chan.sv
module evt_chan
  import evt_chan_pkg::*;
#(
  parameter bit          PER_CAP   = 1'b1,
  parameter int          RTE_W     = 5,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [63:0]      main_cnt,
  input  logic             cnt_run,
  output logic             irq_pulse,
  output logic [RTE_W-1:0] irq_route,
  output logic [63:0]      ticks_left
);

  logic          cfg_wr, lo_wr, hi_wr, mode_exit;
  logic [HW-1:0] cfg_lo;
  logic          ch_en, periodic, setval, m32, trunc;
  logic [DW-1:0] cmp_q;

  assign cfg_wr    = reg_wr && (reg_addr == OFF_CFG_LO);
  assign lo_wr     = reg_wr && (reg_addr == OFF_CMP_LO);
  assign hi_wr     = reg_wr && (reg_addr == OFF_CMP_HI);
  assign mode_exit = cfg_wr && (!reg_wdata[B_M32] || (PER_CAP && reg_wdata[B_PER]));

  evt_chan_cfg #(.PER_CAP(PER_CAP), .RTE_W(RTE_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .wdata    (reg_wdata),
    .cmp_wr   (lo_wr || hi_wr),
    .cfg_lo   (cfg_lo),
    .ch_en    (ch_en),
    .periodic (periodic),
    .setval   (setval),
    .m32      (m32),
    .route    (irq_route),
    .trunc    (trunc)
  );

  evt_chan_cmp u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_wr      (lo_wr),
    .hi_wr      (hi_wr),
    .wdata      (reg_wdata),
    .trunc      (trunc),
    .mode_exit  (mode_exit),
    .ch_en      (ch_en),
    .periodic   (periodic),
    .setval     (setval),
    .m32        (m32),
    .cnt        (main_cnt),
    .glb_en     (cnt_run),
    .cmp_q      (cmp_q),
    .ticks_left (ticks_left),
    .irq_pulse  (irq_pulse)
  );

  // R12: capability word, route window reads as zero
  always_comb begin
    unique case (reg_addr)
      OFF_CFG_LO: reg_rdata = cfg_lo;
      OFF_CFG_HI: reg_rdata = ROUTE_CAP;
      OFF_CMP_LO: reg_rdata = cmp_q[HW-1:0];
      OFF_CMP_HI: reg_rdata = cmp_q[DW-1:HW];
      default:    reg_rdata = '0;
    endcase
  end

  // R1: comparator comes out of reset as all ones
  p_cmp_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> cmp_q == '1);

endmodule

// File: tb/evt_chan_tb.sv
module evt_chan_tb;

  localparam logic [31:0] RCAP  = 32'h00F0_0000;
  localparam logic [4:0]  A_CFG = 5'h00, A_CAP = 5'h04, A_CLO = 5'h08,
                          A_CHI = 5'h0C, A_R0 = 5'h10, A_R1 = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] main_cnt = '0;
  logic        cnt_run = 1'b0;
  logic        irq_pulse;
  logic [4:0]  irq_route;
  logic [63:0] ticks_left;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_chan #(.ROUTE_CAP(RCAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .main_cnt(main_cnt),
    .cnt_run(cnt_run), .irq_pulse(irq_pulse), .irq_route(irq_route),
    .ticks_left(ticks_left)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step(input logic [63:0] v, output logic irq);
    main_cnt = v;
    @(negedge clk);
    #1;
    irq = irq_pulse;
  endtask

  // remaining ticks restated with wide signed arithmetic
  function automatic logic [63:0] exp_left(input logic [63:0] cmp, input logic [63:0] cnt,
                                           input bit narrow);
    longint d;
    if (narrow) begin
      d = longint'({32'd0, cmp[31:0]}) - longint'({32'd0, cnt[31:0]});
      if (d >= 64'sd2147483648) d = d - 64'sd4294967296;
      if (d < -64'sd2147483648) d = d + 64'sd4294967296;
      return (d > 0) ? 64'(d) : 64'd0;
    end
    if (cmp == cnt) return 64'd0;
    d = longint'(cmp - cnt);
    return (d > 0) ? 64'(d) : 64'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, d;
    logic        q;
    logic        any;
    logic [63:0] mcmp;
    int unsigned seed;
    seed = $urandom(32'd4242);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(A_CFG, r); chk("R1 cfg", r, 32'h30);
    rd(A_CLO, r); chk("R1 cmp lo", r, 32'hFFFF_FFFF);
    rd(A_CHI, r); chk("R1 cmp hi", r, 32'hFFFF_FFFF);
    chk("R1 irq", irq_pulse, 0);
    chk("R1 route", irq_route, 0);
    rd(A_CAP, r); chk("R12 cap", r, RCAP);

    // R3 narrowing truncates and keeps the upper half zero
    wr(A_CFG, 32'h100);
    rd(A_CHI, r); chk("R3 trunc hi", r, 0);
    rd(A_CLO, r); chk("R3 trunc lo", r, 32'hFFFF_FFFF);
    wr(A_CHI, 32'h1234);
    rd(A_CHI, r); chk("R3 hi write", r, 0);

    // R2 random configuration writes
    for (int i = 0; i < 20; i++) begin
      d = $urandom;
      wr(A_CFG, d);
      rd(A_CFG, r); chk("R2 cfg", r, (d & 32'h0000_7F4E) | 32'h30);
      chk("R2 route", irq_route, d[13:9]);
    end

    // R4 one-shot comparator writes
    wr(A_CFG, 32'h0);
    wr(A_CLO, 32'h100); wr(A_CHI, 32'h5);
    rd(A_CLO, r); chk("R4 lo", r, 32'h100);
    rd(A_CHI, r); chk("R4 hi", r, 32'h5);

    // R5 R7 periodic loading through the comparator offsets
    wr(A_CFG, 32'h4C);
    wr(A_CLO, 32'h100);
    rd(A_CFG, r); chk("R7 setval cleared", r, 32'h3C);
    wr(A_CHI, 32'h0);
    rd(A_CHI, r); chk("R5 cmp hi kept", r, 32'h5);

    // R8 R9 periodic match and single-cycle pulse
    cnt_run = 1'b1;
    step(64'h5_0000_0100, q); chk("R8 periodic hit", q, 1);
    step(64'h5_0000_0101, q); chk("R8 one cycle", q, 0);
    rd(A_CLO, r); chk("R9 advance", r, 32'h200);
    step(64'h5_0000_0200, q); chk("R8 second hit", q, 1);
    any = 1'b0;
    for (int i = 0; i < 6; i++) begin step(64'h5_0000_0650, q); any |= q; end
    chk("R9 catch-up no irq", any, 0);
    rd(A_CLO, r); chk("R9 catch-up", r, 32'h700);
    cnt_run = 1'b0;

    // R6 R5 64-bit period upper half
    wr(A_CFG, 32'h4C);
    wr(A_CLO, 32'h0);
    wr(A_CHI, 32'hFFFF_FFFF);
    cnt_run = 1'b1;
    step(64'h5_0000_0000, q); chk("R6 hit64", q, 1);
    cnt_run = 1'b0;
    rd(A_CHI, r); chk("R6 period top 63", r, 32'h8000_0004);
    rd(A_CLO, r); chk("R6 lo", r, 0);

    // R6 R9 narrowed period, modulo advance
    wr(A_CFG, 32'h14C);
    rd(A_CHI, r); chk("R3 trunc on set", r, 0);
    wr(A_CLO, 32'hFFFF_FFF0);
    cnt_run = 1'b1;
    step(64'h1234_FFFF_FFF0, q); chk("R8 hit32", q, 1);
    cnt_run = 1'b0;
    rd(A_CLO, r); chk("R6 R9 mod advance", r, 32'h7FFF_FFE0);
    rd(A_CHI, r); chk("R9 hi zero", r, 0);

    // R8 enable gating, one-shot stays
    wr(A_CFG, 32'h0);
    wr(A_CLO, 32'h50); wr(A_CHI, 32'h0);
    cnt_run = 1'b1;
    step(64'h50, q); chk("R8 ch disabled", q, 0);
    cnt_run = 1'b0;
    wr(A_CFG, 32'h4);
    step(64'h50, q); chk("R8 global off", q, 0);
    cnt_run = 1'b1;
    step(64'h50, q); chk("R8 both on", q, 1);
    step(64'h51, q); chk("R8 pulse ends", q, 0);
    rd(A_CLO, r); chk("R9 one-shot holds", r, 32'h50);
    cnt_run = 1'b0;

    // R8 narrowed match ignores upper counter bits
    wr(A_CFG, 32'h104);
    wr(A_CLO, 32'h77);
    cnt_run = 1'b1;
    step(64'hABCD_0000_0000_0077, q); chk("R8 match32", q, 1);
    cnt_run = 1'b0;

    // R11 wrap handling
    main_cnt = 64'hFFFF_FF00;
    wr(A_CLO, 32'h10);
    cnt_run = 1'b1;
    step(64'h10, q);          chk("R11 suppressed", q, 0);
    step(64'hFFFF_FFFF, q);   chk("R11 rollover pulse", q, 1);
    step(64'h1_0000_0010, q); chk("R11 real expiry", q, 1);
    step(64'h1_FFFF_FFFF, q); chk("R11 disarmed", q, 0);
    cnt_run = 1'b0;
    main_cnt = 64'hFFFF_FF00;
    wr(A_CLO, 32'hFFFF_FF80);
    cnt_run = 1'b1;
    step(64'hFFFF_FFFF, q); chk("R11 not armed", q, 0);
    cnt_run = 1'b0;

    // R10 directed narrowed distance
    main_cnt = 64'h9999_FFFF_FF00; #1;
    chk("R10 ahead32", ticks_left, 64'h80);
    main_cnt = 64'h9999_0000_0010; #1;
    chk("R10 behind32", ticks_left, 64'h0);

    // R12 ignored writes
    wr(A_CAP, 32'h0); wr(A_R0, 32'hFFFF_FFFF); wr(A_R1, 32'hFFFF_FFFF);
    rd(A_CAP, r); chk("R12 cap kept", r, RCAP);
    rd(A_R0, r);  chk("R12 route lo", r, 0);
    rd(A_R1, r);  chk("R12 route hi", r, 0);
    rd(A_CFG, r); chk("R12 cfg kept", r, 32'h134);

    // R10 random distances in both widths
    for (int i = 0; i < 24; i++) begin
      bit nar;
      logic [31:0] lo, hi;
      nar = $urandom_range(1, 0) == 1;
      lo = $urandom; hi = $urandom;
      wr(A_CFG, nar ? 32'h100 : 32'h0);
      wr(A_CLO, lo); wr(A_CHI, hi);
      mcmp = nar ? {32'd0, lo} : {hi, lo};
      rd(A_CHI, r); chk("R4 random hi", r, mcmp[63:32]);
      if (i % 2 == 0) main_cnt = mcmp - 64'($urandom_range(40, 0)) + 64'd20;
      else            main_cnt = {$urandom, $urandom};
      #1;
      chk("R10 random", ticks_left, exp_left(mcmp, main_cnt, nar));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule